// File: doc/BRIEF.md
# Extended Carry Multiply-Accumulate Unit

This block holds a 72-bit accumulator made of three registers: a low word (LO), a high word (HI) and an 8-bit extended carry (EXT) above them. It takes two 32-bit operands and a 3-bit operation code. It can form an unsigned integer product or a carry-less (GF(2) polynomial) product. It can load either product into HI/LO, or fold it into the accumulator. Two move operations shift one word at a time through the EXT/HI/LO chain. Together they let software spill the full 72-bit state through a 32-bit port and restore it later.

The multiplier works one operand bit per cycle, so the same datapath serves both product kinds. In integer mode each partial product is added; in polynomial mode it is XORed. A three-state controller sequences the work:

- `ST_IDLE`: waits for `start`. It moves to `ST_MUL` for a multiply-type code or to `ST_WRITE` for any other code.
- `ST_MUL`: runs one shift-and-combine step per cycle. After the last of `WORD_W` steps it moves to `ST_WRITE`.
- `ST_WRITE`: commits the new register values. It always returns to `ST_IDLE`.

Operation codes on `op`: 0 unsigned multiply, 1 polynomial multiply, 2 unsigned multiply-accumulate, 3 polynomial multiply-accumulate, 4 move-out, 5 move-in, 6 and 7 reserved.

Top module: `xmac_unit`

## Requirements
- R1: After reset, LO, HI, EXT and `result` are zero, and `busy` and `done` are low.
- R2: An operation is accepted at a rising edge where `start` is high and `busy` is low, and `busy` is high in the following cycle. Codes 0 to 3 commit at the (WORD_W+1)-th edge after the accepting edge; codes 4 to 7 commit at the first edge after it. `done` is high for exactly the one cycle after the commit edge, and `busy` is low in that cycle.
- R3: Code 0 writes the unsigned 64-bit product a*b: low half to LO, high half to HI, and zero to EXT.
- R4: Code 1 writes the carry-less product. Bit k of the product is the XOR, over all i+j=k, of a[i]&b[j]. The low half goes to LO, the high half to HI, and EXT is cleared.
- R5: Code 2 adds the unsigned product to {EXT,HI,LO} as a 72-bit sum. Carries out of bit 63 enter EXT, and anything above EXT's top bit is dropped.
- R6: Code 3 XORs the carry-less product into {HI,LO}. EXT is left unchanged.
- R7: Code 4 sets `result` to the old LO. LO takes the old HI, HI takes the old EXT zero-extended, and EXT is cleared.
- R8: Code 5 sets EXT to the low 8 bits of the old HI. HI takes the old LO and LO takes operand `a`. It undoes code 4.
- R9: `start` asserted while `busy` is high is ignored: the operation in flight and its code are unchanged.
- R10: Codes 6 and 7 leave LO, HI and EXT unchanged, still complete with a `done` pulse, and set `result` to zero.
- R11: Every commit other than code 4 sets `result` to zero. `result` otherwise holds its value.
- R12: While `busy` is low, LO, HI and EXT do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code, sampled on acceptance |
| a | input | 32 | First operand; the word loaded by move-in |
| b | input | 32 | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Word returned by move-out |
| lo | output | 32 | LO register |
| hi | output | 32 | HI register |
| ext | output | 8 | Extended carry register |

## Verification
The assertions assume that `op`, `a` and `b` only matter in the cycle where `start` meets a low `busy`. They also assume that `start` may stay high or toggle during a busy period without harm. The stimulus relies on this by holding `start` high through part of a multiply with a different code on `op`. It also drives random operands while idle with `start` low. The reserved codes and the saturating EXT case (EXT, HI and LO all ones, plus 1*1) are driven on purpose. This checks that the move operations and the carry path act on the exact boundary values.

// File: rtl/xmac_pkg.sv
package xmac_pkg;

    typedef enum logic [2:0] {
        OP_MUL_U    = 3'd0,
        OP_MUL_P    = 3'd1,
        OP_MAC_U    = 3'd2,
        OP_MAC_P    = 3'd3,
        OP_MOVE_OUT = 3'd4,
        OP_MOVE_IN  = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MUL   = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    function automatic logic is_mul_op(input logic [2:0] code);
        return (code == OP_MUL_U) || (code == OP_MUL_P) ||
               (code == OP_MAC_U) || (code == OP_MAC_P);
    endfunction

    function automatic logic is_poly_op(input logic [2:0] code);
        return (code == OP_MUL_P) || (code == OP_MAC_P);
    endfunction

endpackage

// File: rtl/xmac_ctrl.sv
module xmac_ctrl
    import xmac_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op_in,
    output logic       busy,
    output logic       load,
    output logic       step,
    output logic       poly,
    output logic       wr_en,
    output logic       done,
    output op_e        op_q
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WORD_W - 1);

    state_e           state, nxt;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = is_mul_op(op_in) ? ST_MUL : ST_WRITE;
            ST_MUL:   if (cnt == LAST_STEP) nxt = ST_WRITE;
            ST_WRITE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (state != ST_IDLE);
        load  = (state == ST_IDLE) && start;
        step  = (state == ST_MUL);
        wr_en = (state == ST_WRITE);
        poly  = is_poly_op(op_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            op_q <= OP_MUL_U;
            done <= 1'b0;
        end else begin
            done <= wr_en;
            if (load) begin
                cnt  <= '0;
                op_q <= op_e'(op_in);
            end else if (step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xmac_mul_engine.sv
module xmac_mul_engine #(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic                  poly,
    input  logic [WORD_W-1:0]     a,
    input  logic [WORD_W-1:0]     b,
    output logic [2*WORD_W-1:0]   prod
);
    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] mcand, acc, term, comb_next;
    logic [WORD_W-1:0] mplier;
    logic              poly_q;

    assign term = mplier[0] ? mcand : '0;

    // one shift-and-combine step: add for integers, XOR for GF(2)
    always_comb begin
        if (poly_q) comb_next = acc ^ term;
        else        comb_next = acc + term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            poly_q <= 1'b0;
        end else if (load) begin
            mcand  <= PROD_W'(a);
            mplier <= b;
            acc    <= '0;
            poly_q <= poly;
        end else if (step) begin
            acc    <= comb_next;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
        end
    end

    assign prod = acc;

endmodule

// File: rtl/xmac_acc_bank.sv
module xmac_acc_bank
    import xmac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                wr_en,
    input  op_e                 op_q,
    input  logic [WORD_W-1:0]   din,
    input  logic [2*WORD_W-1:0] prod,
    output logic [WORD_W-1:0]   lo,
    output logic [WORD_W-1:0]   hi,
    output logic [EXT_W-1:0]    ext,
    output logic [WORD_W-1:0]   result
);
    localparam int ACC_W = 2 * WORD_W + EXT_W;

    logic [WORD_W-1:0] din_q;
    logic [ACC_W-1:0]  sum;
    logic [EXT_W-1:0]  hi_to_ext;
    logic [WORD_W-1:0] ext_to_hi;

    assign sum = {ext, hi, lo} + ACC_W'(prod);

    generate
        if (EXT_W < WORD_W) begin : g_narrow_ext
            assign hi_to_ext = hi[EXT_W-1:0];
            assign ext_to_hi = {{(WORD_W-EXT_W){1'b0}}, ext};
        end else begin : g_full_ext
            assign hi_to_ext = EXT_W'(hi);
            assign ext_to_hi = ext[WORD_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q  <= '0;
            lo     <= '0;
            hi     <= '0;
            ext    <= '0;
            result <= '0;
        end else begin
            if (load) din_q <= din;
            if (wr_en) begin
                result <= '0;
                unique case (op_q)
                    OP_MUL_U, OP_MUL_P: begin
                        {hi, lo} <= prod;
                        ext      <= '0;
                    end
                    OP_MAC_U: {ext, hi, lo} <= sum;
                    OP_MAC_P: {hi, lo} <= {hi, lo} ^ prod;
                    OP_MOVE_OUT: begin
                        result <= lo;
                        lo     <= hi;
                        hi     <= ext_to_hi;
                        ext    <= '0;
                    end
                    OP_MOVE_IN: begin
                        ext <= hi_to_ext;
                        hi  <= lo;
                        lo  <= din_q;
                    end
                    OP_RSV6, OP_RSV7: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/xmac_unit.sv
module xmac_unit
    import xmac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic [WORD_W-1:0] lo,
    output logic [WORD_W-1:0] hi,
    output logic [EXT_W-1:0]  ext
);
    logic                load, step, poly, wr_en;
    op_e                 op_q;
    logic [2*WORD_W-1:0] prod;

    xmac_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op),
        .busy(busy), .load(load), .step(step), .poly(poly),
        .wr_en(wr_en), .done(done), .op_q(op_q)
    );

    xmac_mul_engine #(.WORD_W(WORD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .poly(poly),
        .a(a), .b(b), .prod(prod)
    );

    xmac_acc_bank #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(load), .wr_en(wr_en), .op_q(op_q),
        .din(a), .prod(prod), .lo(lo), .hi(hi), .ext(ext), .result(result)
    );

endmodule

// File: rtl/xmac_checker.sv
module xmac_checker
    import xmac_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              wr_en,
    input op_e               op_q,
    input logic [WORD_W-1:0] result,
    input logic [WORD_W-1:0] lo,
    input logic [WORD_W-1:0] hi,
    input logic [EXT_W-1:0]  ext
);
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wr_en |=> $stable(op_q));

    assert_mul_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (op_q == OP_MUL_U || op_q == OP_MUL_P) |=> ext == '0);

    assert_polymac_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && op_q == OP_MAC_P |=> $stable(ext));

    assert_move_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && op_q == OP_MOVE_OUT |=>
            result == $past(lo) && lo == $past(hi) && ext == '0 &&
            hi == WORD_W'($past(ext)));

    assert_move_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && op_q == OP_MOVE_IN |=>
            hi == $past(lo) && ext == EXT_W'($past(hi)));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (op_q == OP_RSV6 || op_q == OP_RSV7) |=>
            $stable(lo) && $stable(hi) && $stable(ext));

    assert_result_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && op_q != OP_MOVE_OUT |=> result == '0);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(lo) && $stable(hi) && $stable(ext));

endmodule

bind xmac_unit xmac_checker #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .op_q(op_q), .result(result), .lo(lo), .hi(hi), .ext(ext)
);

// File: tb/sim_xmac_unit.sv
module sim_xmac_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int E = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] a = '0, b = '0;
    logic         busy, done;
    logic [W-1:0] result, lo, hi;
    logic [E-1:0] ext;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit fin = 0;
    string cur_tag = "R1";

    xmac_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .busy(busy), .done(done), .result(result), .lo(lo), .hi(hi), .ext(ext));

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model
    logic [W-1:0] m_lo, m_hi, m_res, p_a, p_b;
    logic [E-1:0] m_ext;
    logic [2:0]   p_op;
    logic         m_done;
    int           m_cnt;

    function automatic logic [63:0] gf2_mul(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] r = '0;
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                r[i+j] = r[i+j] ^ (x[i] & y[j]);
        return r;
    endfunction

    task automatic apply_model();
        logic [63:0] p;
        logic [71:0] s;
        m_res = '0;
        case (p_op)
            3'd0: begin p = {32'd0, p_a} * {32'd0, p_b}; {m_hi, m_lo} = p; m_ext = '0; end
            3'd1: begin p = gf2_mul(p_a, p_b); {m_hi, m_lo} = p; m_ext = '0; end
            3'd2: begin
                s = {m_ext, m_hi, m_lo} + {8'd0, ({32'd0, p_a} * {32'd0, p_b})};
                {m_ext, m_hi, m_lo} = s;
            end
            3'd3: {m_hi, m_lo} = {m_hi, m_lo} ^ gf2_mul(p_a, p_b);
            3'd4: begin m_res = m_lo; m_lo = m_hi; m_hi = {24'd0, m_ext}; m_ext = '0; end
            3'd5: begin m_ext = m_hi[7:0]; m_hi = m_lo; m_lo = p_a; end
            default: ;
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lo = '0; m_hi = '0; m_ext = '0; m_res = '0; m_done = 0; m_cnt = 0;
            p_op = '0; p_a = '0; p_b = '0;
        end else begin
            m_done = 0;
            if (m_cnt == 0) begin
                if (start) begin
                    p_op = op; p_a = a; p_b = b;
                    m_cnt = (op < 3'd4) ? W + 1 : 1;
                end
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin apply_model(); m_done = 1; end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R2", "busy", 64'(busy), 64'(m_cnt > 0));
            chk("R2", "done", 64'(done), 64'(m_done));
            chk(cur_tag, "lo", 64'(lo), 64'(m_lo));
            chk(cur_tag, "hi", 64'(hi), 64'(m_hi));
            chk(cur_tag, "ext", 64'(ext), 64'(m_ext));
            chk((p_op == 3'd4) ? "R7" : "R11", "result", 64'(result), 64'(m_res));
        end
    end

    task automatic finish_run();
        fin = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    task automatic run_op(input string tag, input logic [2:0] c,
                          input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        cur_tag = tag;
        op = c; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "lo", 64'(lo), 64'd0);
        chk("R1", "hi", 64'(hi), 64'd0);
        chk("R1", "ext", 64'(ext), 64'd0);
        chk("R1", "result", 64'(result), 64'd0);
        chk("R1", "busy_done", 64'({busy, done}), 64'd0);
        rst_n = 1'b1;

        run_op("R3", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R3", "max*max", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
        run_op("R3", 3'd0, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R4", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R4", "clmul all ones", {hi, lo}, 64'h5555_5555_5555_5555);
        run_op("R4", 3'd1, 32'h8000_0001, 32'h8000_0003);
        // R5 carry into ext, then wrap above ext
        run_op("R5", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) run_op("R5", 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R8", 3'd5, 32'h0000_00FF, 32'd0);
        run_op("R8", 3'd5, 32'hFFFF_FFFF, 32'd0);
        run_op("R8", 3'd5, 32'hFFFF_FFFF, 32'd0);
        chk("R8", "ext saturated", 64'(ext), 64'hFF);
        run_op("R5", 3'd2, 32'd1, 32'd1);
        chk("R5", "wrap to zero", {56'd0, ext} | {hi, lo}, 64'd0);
        // R6 poly accumulate keeps ext
        run_op("R8", 3'd5, 32'h0000_00A5, 32'd0);
        run_op("R8", 3'd5, 32'h1111_2222, 32'd0);
        run_op("R8", 3'd5, 32'h3333_4444, 32'd0);
        run_op("R6", 3'd3, 32'hDEAD_BEEF, 32'hCAFE_F00D);
        chk("R6", "ext kept", 64'(ext), 64'hA5);
        // R7 move-out chain
        run_op("R7", 3'd4, 32'd0, 32'd0);
        run_op("R7", 3'd4, 32'd0, 32'd0);
        run_op("R7", 3'd4, 32'd0, 32'd0);
        chk("R7", "third word", 64'(result), 64'hA5);
        // R9 start held high during busy with another code
        @(negedge clk);
        cur_tag = "R9";
        op = 3'd0; a = 32'h0001_0003; b = 32'h0000_0007; start = 1'b1;
        @(negedge clk);
        op = 3'd4;
        repeat (5) @(negedge clk);
        start = 1'b0;
        while (m_cnt > 0) @(negedge clk);
        chk("R9", "product of first op", {hi, lo}, 64'h0000_0000_0007_0015);
        // R10 reserved codes
        run_op("R10", 3'd6, 32'h5555_AAAA, 32'h1234);
        run_op("R10", 3'd7, 32'hFFFF_0000, 32'h4321);
        // R12 idle with changing inputs
        cur_tag = "R12";
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            a = $urandom; b = $urandom; op = 3'($urandom);
        end
        // mixed traffic
        for (int k = 0; k < 60; k++)
            run_op("R3", 3'($urandom_range(0, 7)), $urandom, $urandom);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule